// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block sits between a bank of interrupt request lines and the system's message fabric. Each pin has a 64-bit redirection entry, held by a neighbouring register block and presented here as one flat vector. The engine keeps a pending bit per pin (IRR) and a remote-IRR bit per level pin. It applies edge or level semantics from each entry and converts every deliverable request into one 32-bit address / 32-bit data interrupt message.

Messages leave one at a time over a valid/ready handshake. An end-of-interrupt (EOI) broadcast carries a vector. It releases the remote-IRR of every level entry with that vector, so a line that is still asserted is delivered again. The remote-IRR bits are exported so that the register block can merge them into its view of the table. The vector for external-controller delivery mode arrives on an input port.

Entry layout: vector [7:0], delivery mode [10:8], destination mode [11], trigger mode [15] (1 = level), mask [16], destination/index [63:48]. All other entry bits are ignored.

Top module: `irq_redir_engine`

## Requirements
- R1: While rst_n is low, msg_valid, irr_o and remote_irr_o are all zero.
- R2: Input line 0 drives pin 2, OR-ed with input line 2. Pin 0 never becomes pending. Every other input line drives the pin with the same index.
- R3: For a level pin, the IRR bit equals the line level sampled at the previous clock edge, whatever the mask is. A masked level pin is never delivered.
- R4: For an edge pin, a rising line sets IRR only if the pin is unmasked. A rise on a masked pin is dropped, and unmasking the pin later produces no message.
- R5: When the output stage is free, the eligible pin with the lowest index is loaded. A pin is eligible when its IRR bit is set, its mask bit is clear, and it is either an edge pin or has remote-IRR clear.
- R6: Loading an edge pin clears its IRR bit, so one rise gives one message. A pending request is loaded at the first clock edge after its IRR bit is set.
- R7: Loading a level pin sets its remote-IRR bit. While that bit is set, the pin sends no further message, even if its line stays high.
- R8: The message address is 0xFEE00000 OR (destination/index << 4) OR (destination mode << 2). The message data is vector | (delivery mode << 8) | (trigger << 15).
- R9: If the delivery mode is 3'b111, the data vector is taken from extint_vec instead of the entry's vector field.
- R10: An EOI with vector V clears remote-IRR on every level entry whose remote-IRR is set and whose vector field equals V. An unmasked entry whose line is still high is then delivered again.
- R11: While msg_valid is high and msg_ready is low, msg_addr and msg_data hold their values and no new pin is loaded. Edges and EOIs that arrive in that time are still recorded.
- R12: The remote-IRR bit of a pin whose entry is set to edge trigger reads zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | Raw interrupt request lines |
| rte_flat | input | NUM_PINS*64 | Redirection entries, pin p at bits [p*64+63 : p*64] |
| extint_vec | input | 8 | Vector supplied by the external controller |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_ready | input | 1 | The fabric accepts the message |
| msg_valid | output | 1 | A message is offered |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| irr_o | output | NUM_PINS | Pending bit per pin |
| remote_irr_o | output | NUM_PINS | Remote-IRR bit per pin |

## Verification
The bench pulses line 0 and expects a pin 2 message. A design without the reroute would mark pin 0 pending instead. It raises an edge while the pin is masked and then unmasks it; a design that latched masked edges would send a late message. It holds two level lines with the same vector high and checks that only one message per pin appears until an EOI. A missing coalesce would flood the output, and a single-match EOI would strand one pin. It stalls ready while new edges arrive. A design that dropped events or let the held message change would lose deliveries or corrupt addresses.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int          ENTRY_W      = 64;
  localparam int          REROUTE_PIN  = 2;
  localparam logic [31:0] MSG_BASE     = 32'hFEE0_0000;
  localparam logic [2:0]  DLV_EXTINT   = 3'b111;
  localparam int          ADDR_DEST_SH = 4;
  localparam int          ADDR_MODE_SH = 2;
  localparam int          DATA_DLV_SH  = 8;
  localparam int          DATA_TRIG_SH = 15;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        trig_lvl;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vector;
  } rte_fields_t;

  function automatic rte_fields_t rte_decode(input logic [ENTRY_W-1:0] e);
    rte_fields_t f;
    f.dest     = e[63:48];
    f.mask     = e[16];
    f.trig_lvl = e[15];
    f.dmode    = e[11];
    f.dlv      = e[10:8];
    f.vector   = e[7:0];
    return f;
  endfunction

  function automatic logic [31:0] msg_addr_of(input rte_fields_t f);
    return MSG_BASE | (32'(f.dest) << ADDR_DEST_SH) | (32'(f.dmode) << ADDR_MODE_SH);
  endfunction

  function automatic logic [31:0] msg_data_of(input rte_fields_t f, input logic [7:0] ext);
    logic [7:0] v;
    v = (f.dlv == DLV_EXTINT) ? ext : f.vector;
    return 32'(v) | (32'(f.dlv) << DATA_DLV_SH) | (32'(f.trig_lvl) << DATA_TRIG_SH);
  endfunction

endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] edge_clr,
  output logic [NUM_PINS-1:0] irr
);

  logic [NUM_PINS-1:0] line;
  logic [NUM_PINS-1:0] line_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] irr_next;

  // Input-to-pin map: line 0 is folded onto the reroute pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == 0) begin : g_zero
      assign line[p] = 1'b0;
    end else if (p == REROUTE_PIN) begin : g_fold
      assign line[p] = irq_in[p] | irq_in[0];
    end else begin : g_direct
      assign line[p] = irq_in[p];
    end
  end

  assign rise = line & ~line_q;

  always_comb begin
    irr_next = (lvl_mode & line) |
               (~lvl_mode & ((irr & ~edge_clr) | (rise & ~pin_mask)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      irr    <= '0;
    end else begin
      line_q <= line;
      irr    <= irr_next;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irq_in,
  input  logic [NUM_PINS*ENTRY_W-1:0] rte_flat,
  input  logic [7:0]                  extint_vec,
  input  logic                        eoi_valid,
  input  logic [7:0]                  eoi_vector,
  input  logic                        msg_ready,
  output logic                        msg_valid,
  output logic [31:0]                 msg_addr,
  output logic [31:0]                 msg_data,
  output logic [NUM_PINS-1:0]         irr_o,
  output logic [NUM_PINS-1:0]         remote_irr_o
);

  rte_fields_t         fld [NUM_PINS];
  logic [NUM_PINS-1:0] lvl_mode;
  logic [NUM_PINS-1:0] pin_mask;
  logic [NUM_PINS-1:0] eoi_hit;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] sel_onehot;
  logic [NUM_PINS-1:0] edge_clr;
  logic [NUM_PINS-1:0] rirr_set;
  logic [NUM_PINS-1:0] rirr;
  logic [NUM_PINS-1:0] rirr_next;
  logic                pick_found;
  logic [IDX_W-1:0]    pick_idx;
  logic                advance;
  logic                load_fire;
  logic                load_level;
  logic                load_masked;
  rte_fields_t         sel_fld;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    assign fld[p]      = rte_decode(rte_flat[p*ENTRY_W +: ENTRY_W]);
    assign lvl_mode[p] = fld[p].trig_lvl;
    assign pin_mask[p] = fld[p].mask;
    assign eoi_hit[p]  = eoi_valid && rirr[p] && (fld[p].vector == eoi_vector);
  end

  irq_in_stage #(.NUM_PINS(NUM_PINS)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .lvl_mode (lvl_mode),
    .pin_mask (pin_mask),
    .edge_clr (edge_clr),
    .irr      (irr_o)
  );

  assign eligible = irr_o & ~pin_mask & (~lvl_mode | ~rirr);

  irq_prio_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req   (eligible),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign advance     = !msg_valid || msg_ready;
  assign load_fire   = advance && pick_found;
  assign sel_onehot  = load_fire ? (NUM_PINS'(1) << pick_idx) : '0;
  assign edge_clr    = sel_onehot & ~lvl_mode;
  assign rirr_set    = sel_onehot & lvl_mode;
  assign load_level  = lvl_mode[pick_idx];
  assign load_masked = pin_mask[pick_idx];
  assign sel_fld     = fld[pick_idx];

  // Remote-IRR: set on level delivery, released by matching EOI, forced low for edge entries
  assign rirr_next = (rirr | rirr_set) & ~eoi_hit & lvl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rirr <= '0;
    end else begin
      rirr <= rirr_next;
    end
  end

  assign remote_irr_o = rirr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (advance) begin
      msg_valid <= pick_found;
      if (pick_found) begin
        msg_addr <= msg_addr_of(sel_fld);
        msg_data <= msg_data_of(sel_fld, extint_vec);
      end
    end
  end

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [31:0]         msg_addr,
  input logic [31:0]         msg_data,
  input logic [NUM_PINS-1:0] irr_o,
  input logic [NUM_PINS-1:0] remote_irr_o,
  input logic                eoi_valid,
  input logic [NUM_PINS-1:0] eoi_hit,
  input logic                load_fire,
  input logic                load_level,
  input logic                load_masked,
  input logic [IDX_W-1:0]    pick_idx
);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_pin0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irr_o[0]);

  p_no_masked_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> !load_masked);

  p_level_sets_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && load_level |=> remote_irr_o[$past(pick_idx)]);

  p_eoi_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> (($past(eoi_hit) & remote_irr_o) == '0));

  p_addr_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[31:20] == 12'hFEE);

endmodule

bind irq_redir_engine irq_redir_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_addr     (msg_addr),
  .msg_data     (msg_data),
  .irr_o        (irr_o),
  .remote_irr_o (remote_irr_o),
  .eoi_valid    (eoi_valid),
  .eoi_hit      (eoi_hit),
  .load_fire    (load_fire),
  .load_level   (load_level),
  .load_masked  (load_masked),
  .pick_idx     (pick_idx)
);

// File: tb/irq_redir_engine_tb.sv
`timescale 1ns/1ps
module irq_redir_engine_tb;

  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   irq_in = '0;
  logic [63:0]    rte [N];
  logic [N*64-1:0] rte_flat;
  logic [7:0]     extint_vec = 8'h00;
  logic           eoi_valid = 1'b0;
  logic [7:0]     eoi_vector = 8'h00;
  logic           msg_ready = 1'b1;
  logic           msg_valid;
  logic [31:0]    msg_addr, msg_data;
  logic [N-1:0]   irr_o, remote_irr_o;

  always #2.5 clk = ~clk;

  always_comb for (int p = 0; p < N; p++) rte_flat[p*64 +: 64] = rte[p];

  irq_redir_engine #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
    .extint_vec(extint_vec), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .irr_o(irr_o), .remote_irr_o(remote_irr_o)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic bit e_lvl(int p);   return rte[p][15]; endfunction
  function automatic bit e_msk(int p);   return rte[p][16]; endfunction
  function automatic int e_vec(int p);   return int'(rte[p] & 64'hFF); endfunction
  function automatic int e_dlv(int p);   return int'((rte[p] >> 8) & 64'h7); endfunction

  logic [N-1:0] m_irr, m_rirr, m_prev;
  bit           m_valid;
  logic [31:0]  m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0] ln, nirr, nrirr;
    int sel, v;
    if (!rst_n) begin
      m_irr = '0; m_rirr = '0; m_prev = '0; m_valid = 0; m_addr = 0; m_data = 0;
    end else begin
      for (int p = 0; p < N; p++)
        ln[p] = (p == 0) ? 1'b0 : (p == 2) ? (irq_in[0] | irq_in[2]) : irq_in[p];
      sel = -1;
      if (!m_valid || msg_ready) begin
        for (int p = 0; p < N; p++)
          if (sel < 0 && m_irr[p] && !e_msk(p) && (!e_lvl(p) || !m_rirr[p])) sel = p;
        m_valid = (sel >= 0);
        if (sel >= 0) begin
          v = (e_dlv(sel) == 7) ? int'(extint_vec) : e_vec(sel);
          m_addr = 32'hFEE0_0000 + 32'(rte[sel][63:48]) * 16 + (rte[sel][11] ? 4 : 0);
          m_data = 32'(v) + 32'(e_dlv(sel)) * 256 + (e_lvl(sel) ? 32'h8000 : 0);
        end
      end
      for (int p = 0; p < N; p++) begin
        if (e_lvl(p)) nirr[p] = ln[p];
        else nirr[p] = (m_irr[p] && sel != p) || (ln[p] && !m_prev[p] && !e_msk(p));
        nrirr[p] = e_lvl(p) && (m_rirr[p] || sel == p) &&
                   !(eoi_valid && m_rirr[p] && e_vec(p) == int'(eoi_vector));
      end
      m_irr = nirr; m_rirr = nrirr; m_prev = ln;
    end
  end

  // ---------------- per-cycle comparison and message log ----------------
  int          cnt [256];
  logic [31:0] q_addr[$], q_data[$];

  always @(negedge clk) begin
    if (rst_n) begin
      check(msg_valid == m_valid, {cur_req, " valid"}, msg_valid, m_valid);
      if (m_valid) begin
        check(msg_addr == m_addr, {cur_req, " addr"}, msg_addr, m_addr);
        check(msg_data == m_data, {cur_req, " data"}, msg_data, m_data);
      end
      check(irr_o == m_irr, {cur_req, " irr"}, irr_o, m_irr);
      check(remote_irr_o == m_rirr, {cur_req, " rirr"}, remote_irr_o, m_rirr);
      if (msg_valid && msg_ready) begin
        cnt[msg_data[7:0]]++;
        q_addr.push_back(msg_addr);
        q_data.push_back(msg_data);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_log();
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    q_addr.delete();
    q_data.delete();
  endtask

  task automatic pulse(input int p);
    irq_in[p] = 1'b1; tick(1); irq_in[p] = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v; tick(1); eoi_valid = 1'b0;
  endtask

  function automatic logic [63:0] mk(logic [7:0] vec, logic [2:0] dlv, bit dmode,
                                     bit lvl, bit msk, logic [15:0] dest);
    logic [63:0] e = '0;
    e[63:48] = dest; e[16] = msk; e[15] = lvl; e[11] = dmode; e[10:8] = dlv; e[7:0] = vec;
    return e;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rte[0] = mk(8'h10, 3'd0, 0, 0, 0, 16'h0000);
    rte[1] = mk(8'h31, 3'd0, 0, 0, 0, 16'h0012);
    rte[2] = mk(8'h22, 3'd1, 0, 0, 0, 16'h0100);
    rte[3] = mk(8'h43, 3'd0, 1, 1, 0, 16'hABCD);
    rte[4] = mk(8'h54, 3'd0, 0, 0, 1, 16'h0004);
    rte[5] = mk(8'h00, 3'd7, 0, 0, 0, 16'h0005);
    rte[6] = mk(8'h66, 3'd0, 0, 1, 1, 16'h0006);
    rte[7] = mk(8'h43, 3'd0, 0, 1, 0, 16'h0007);
    clear_log();
    tick(3);
    // R1: reset state
    check(msg_valid == 1'b0, "R1 valid", msg_valid, 0);
    check(irr_o == '0, "R1 irr", irr_o, 0);
    check(remote_irr_o == '0, "R1 rirr", remote_irr_o, 0);
    rst_n = 1'b1;
    tick(2);

    // R2: line 0 reaches pin 2, pin 0 stays idle
    cur_req = "R2"; clear_log();
    pulse(0); tick(4);
    check(cnt[8'h22] == 1, "R2 pin2 msgs", cnt[8'h22], 1);
    check(cnt[8'h10] == 0, "R2 pin0 msgs", cnt[8'h10], 0);

    // R4: masked edge dropped, not latched
    cur_req = "R4"; clear_log();
    pulse(4); tick(4);
    check(cnt[8'h54] == 0, "R4 masked edge", cnt[8'h54], 0);
    rte[4][16] = 1'b0; tick(4);
    check(cnt[8'h54] == 0, "R4 after unmask", cnt[8'h54], 0);
    pulse(4); tick(4);
    check(cnt[8'h54] == 1, "R4 unmasked edge", cnt[8'h54], 1);

    // R5 / R6 / R8: simultaneous requests under stall, lowest index first
    cur_req = "R5"; clear_log();
    msg_ready = 1'b0;
    irq_in[3] = 1'b1; pulse(1); tick(4);
    msg_ready = 1'b1; tick(4);
    check(q_data.size() == 2, "R5 count", q_data.size(), 2);
    if (q_data.size() == 2) begin
      check(q_data[0] == 32'h0000_0031, "R5 first pin1 / R8 data", q_data[0], 32'h31);
      check(q_addr[0] == 32'hFEE0_0120, "R8 addr pin1", q_addr[0], 32'hFEE00120);
      check(q_data[1] == 32'h0000_8043, "R8 data level", q_data[1], 32'h8043);
      check(q_addr[1] == 32'hFEEA_BCD4, "R8 addr dmode", q_addr[1], 32'hFEEABCD4);
    end
    check(cnt[8'h31] == 1, "R6 single edge msg", cnt[8'h31], 1);

    // R7: level held high is coalesced; two pins share vector 0x43
    cur_req = "R7"; clear_log();
    irq_in[7] = 1'b1; tick(10);
    check(cnt[8'h43] == 1, "R7 coalesced", cnt[8'h43], 1);
    check(remote_irr_o[3] && remote_irr_o[7], "R7 rirr set", remote_irr_o, 8'h88);

    // R10: EOI releases every match and re-delivers held lines
    cur_req = "R10"; clear_log();
    eoi(8'h43); tick(5);
    check(cnt[8'h43] == 2, "R10 redelivery", cnt[8'h43], 2);
    eoi(8'h99); tick(3);
    check(remote_irr_o[3] && remote_irr_o[7], "R10 wrong vector", remote_irr_o, 8'h88);
    irq_in[3] = 1'b0; irq_in[7] = 1'b0; tick(1);
    eoi(8'h43); tick(4);
    check(cnt[8'h43] == 2, "R10 no redelivery", cnt[8'h43], 2);
    check(remote_irr_o == '0, "R10 rirr clear", remote_irr_o, 0);

    // R9: external vector source
    cur_req = "R9"; clear_log();
    extint_vec = 8'h77; pulse(5); tick(4);
    check(cnt[8'h77] == 1, "R9 extint vector", cnt[8'h77], 1);
    if (q_data.size() > 0)
      check(q_data[0] == 32'h0000_0777, "R9 extint data", q_data[0], 32'h777);

    // R3: masked level pin tracks its line without delivering
    cur_req = "R3"; clear_log();
    irq_in[6] = 1'b1; tick(2);
    check(irr_o[6] == 1'b1, "R3 irr follows high", irr_o[6], 1);
    irq_in[6] = 1'b0; tick(2);
    check(irr_o[6] == 1'b0, "R3 irr follows low", irr_o[6], 0);
    check(cnt[8'h66] == 0, "R3 masked level", cnt[8'h66], 0);

    // R11: events during a stall are kept
    cur_req = "R11"; clear_log();
    msg_ready = 1'b0;
    pulse(1); tick(2); pulse(2); tick(1); pulse(1); tick(6);
    check(msg_valid == 1'b1, "R11 held valid", msg_valid, 1);
    msg_ready = 1'b1; tick(6);
    check(cnt[8'h31] == 2, "R11 pin1 msgs", cnt[8'h31], 2);
    check(cnt[8'h22] == 1, "R11 pin2 msgs", cnt[8'h22], 1);

    // R12: switching to edge trigger clears remote-IRR
    cur_req = "R12"; clear_log();
    irq_in[3] = 1'b1; tick(4);
    check(remote_irr_o[3] == 1'b1, "R12 rirr before", remote_irr_o[3], 1);
    rte[3][15] = 1'b0; tick(2);
    check(remote_irr_o[3] == 1'b0, "R12 rirr after", remote_irr_o[3], 0);
    irq_in[3] = 1'b0; tick(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule